// File: doc/BRIEF.md
# ADC Result Read Port

This block is the host side of a sampling converter's result path. When the conversion engine reports a finished 14-bit sample, the block copies it into a holding buffer. The host can then read the held value while the next sample is being acquired or converted, and throughput does not suffer. A register-select input chooses between a status byte and the held sample. A width input chooses one 16-bit transfer or two 8-bit transfers, taken high half first.

The data pins are modelled as a value vector plus a per-bit drive enable. A bit whose enable is low stands for a pin in high impedance. Pins are driven only while chip-select and read are both low. A read is counted in the clock cycle where the strobe pair stops being active. When a read is counted, two things happen: the end-of-conversion flag is released, and a narrow data read advances the half pointer. A sample that finishes during a read is parked and copied into the buffer when that read ends, so a host never sees a value built from two samples.

Top module: `adc_rdport`

## Requirements
- R1: After a synchronous reset, no pin is driven. The held sample is zero, the end-of-conversion flag reads 1 (no result waiting) and the half pointer selects the high half.
- R2: `data_en` is all zeros whenever `cs_n` or `rd_n` is high. Pins are enabled only while both are low.
- R3: A read with `addr_sel`=0 drives only bits 7..0 with the status byte. Bit 7 is end-of-conversion (active low). Bit 6 is end-of-track, equal to the inverse of `acq_settled`. Bit 5 is `conv_active`, bit 4 is `cal_active` and bit 0 is `trk_active`. Bit 2 is the half pointer (0 = the next narrow read returns the high half). Bits 3 and 1 read 0.
- R4: A data read (`addr_sel`=1) with `wide_mode`=1 drives all 16 bits. Bits 15..2 carry the held sample, MSB at bit 15, and bits 1..0 are 0.
- R5: A narrow data read (`wide_mode`=0) drives only bits 7..0. When the pointer selects the high half, the read returns sample bits 13..6.
- R6: When the pointer selects the low half, a narrow data read returns sample bits 5..0 on bits 7..2, with zeros on bits 1..0. Repeated narrow reads alternate high, low, high, and so on.
- R7: The pointer toggles only at the end of a narrow data read. Status reads and wide data reads leave it unchanged.
- R8: End-of-conversion goes to 0 in the cycle after a sample is loaded. It returns to 1 at the end of the next read of any kind.
- R9: Loading a new sample resets the pointer to the high half.
- R10: A sample that completes while a read is active does not change the returned value during that read. It is loaded in the cycle the read ends.
- R11: If several samples complete during one read, the last one is the one loaded when the read ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_done | input | 1 | One-cycle pulse: a conversion has finished |
| conv_result | input | 14 | Finished sample, valid with `conv_done` |
| trk_active | input | 1 | Front end is tracking the input |
| conv_active | input | 1 | Engine is converting the held input |
| cal_active | input | 1 | Engine is calibrating |
| acq_settled | input | 1 | Input has been acquired to full accuracy |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| addr_sel | input | 1 | 0 = status byte, 1 = sample data |
| wide_mode | input | 1 | 1 = one 16-bit read, 0 = two 8-bit reads |
| data_out | output | 16 | Pin values |
| data_en | output | 16 | Per-pin drive enable (0 = high impedance) |

## Verification
The assertions check these rules on every cycle: pins are undriven outside an active strobe pair, a status read enables only the low byte with its reserved bits at zero, the held sample stays stable while a read is active, and the flag and pointer respond correctly to each load and each read end. Only the bench scenarios can show the exact bit packing of wide and narrow results across many sample values, the alternating half sequence over repeated reads, the mapping of the phase inputs into the status byte, and that a sample parked during a held read is the newest one.

// File: rtl/adc_rdport_pkg.sv
// Package: shared status bit positions and the half-pointer type.
// Assumes an 8-bit status byte.
package adc_rdport_pkg;
    localparam int ST_EOC  = 7;
    localparam int ST_EOT  = 6;
    localparam int ST_CONV = 5;
    localparam int ST_CAL  = 4;
    localparam int ST_RSV3 = 3;
    localparam int ST_PTR  = 2;
    localparam int ST_RSV1 = 1;
    localparam int ST_TRK  = 0;

    typedef enum logic {
        PTR_HIGH = 1'b0,
        PTR_LOW  = 1'b1
    } half_ptr_e;
endpackage

// File: rtl/adc_rdport_strobe.sv
// Module: read strobe tracker.
// Decodes an active read from chip-select and read, both active low.
// Remembers the register select and width of the current read, and flags
// the cycle in which the read ends.
// Assumes the strobes are synchronous to clk.
module adc_rdport_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic addr_sel,
    input  logic wide_mode,
    output logic rd_active,
    output logic rd_end,
    output logic end_is_data,
    output logic end_is_wide
);
    logic act_q;
    logic addr_q;
    logic wide_q;

    // Read is active while both strobes are low.
    always_comb begin
        rd_active = ~cs_n & ~rd_n;
    end

    // Remember the previous activity and the select/width seen during the read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            addr_q <= 1'b0;
            wide_q <= 1'b0;
        end else begin
            act_q <= rd_active;
            if (rd_active) begin
                addr_q <= addr_sel;
                wide_q <= wide_mode;
            end
        end
    end

    // A read ends in the first cycle after it was active and no longer is.
    always_comb begin
        rd_end      = act_q & ~rd_active;
        end_is_data = addr_q;
        end_is_wide = wide_q;
    end
endmodule

// File: rtl/adc_rdport_buffer.sv
// Module: sample holding buffer with a deferred load.
// Copies a finished sample into the held register unless a read is active.
// A sample that arrives during a read is parked, and a newer one replaces
// it; the parked sample is loaded in the first cycle with no read.
module adc_rdport_buffer #(
    parameter int RES_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    input  logic             rd_active,
    output logic [RES_W-1:0] held_q,
    output logic             load
);
    logic             park_v;
    logic [RES_W-1:0] park_d;
    logic [RES_W-1:0] next_d;

    // Choose the newest candidate and decide whether it may be loaded now.
    always_comb begin
        next_d = conv_done ? conv_result : park_d;
        load   = (conv_done | park_v) & ~rd_active;
    end

    // Load the held sample, or park an incoming sample while a read is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
            park_v <= 1'b0;
            park_d <= '0;
        end else if (load) begin
            held_q <= next_d;
            park_v <= 1'b0;
        end else if (conv_done) begin
            park_v <= 1'b1;
            park_d <= conv_result;
        end
    end

    AST_HOLD_DURING_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_active |=> $stable(held_q)); // R10
    AST_PARK_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && rd_active) |=> (park_v && park_d == $past(conv_result))); // R11
endmodule

// File: rtl/adc_rdport_status.sv
// Module: end-of-conversion flag and half pointer.
// A load clears the flag to 0 and resets the pointer to the high half;
// a load takes priority over a read end in the same cycle.
// The end of any read sets the flag back to 1.
// The end of a narrow data read toggles the pointer.
module adc_rdport_status
    import adc_rdport_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  logic      rd_end,
    input  logic      end_is_data,
    input  logic      end_is_wide,
    output logic      eoc_n,
    output half_ptr_e ptr
);
    logic narrow_end;

    // A narrow data read has just finished.
    always_comb begin
        narrow_end = rd_end & end_is_data & ~end_is_wide;
    end

    // Update the flag and the pointer on a load or at the end of a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoc_n <= 1'b1;
            ptr   <= PTR_HIGH;
        end else if (load) begin
            eoc_n <= 1'b0;
            ptr   <= PTR_HIGH;
        end else begin
            if (rd_end) begin
                eoc_n <= 1'b1;
            end
            if (narrow_end) begin
                ptr <= (ptr == PTR_HIGH) ? PTR_LOW : PTR_HIGH;
            end
        end
    end

    AST_LOAD_DROPS_EOC: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !eoc_n); // R8
    AST_READ_RAISES_EOC: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_end && !load) |=> eoc_n); // R8
    AST_LOAD_PTR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ptr == PTR_HIGH)); // R9
    AST_PTR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(rd_end && end_is_data && !end_is_wide)) |=> $stable(ptr)); // R7
endmodule

// File: rtl/adc_rdport_drive.sv
// Module: pin value and enable generator.
// Combinational. Builds the status byte and the wide and narrow data
// formats, and enables only the pins that belong to the current read.
// Assumes BYTE_W < RES_W <= BUS_W and RES_W <= 2*BYTE_W.
module adc_rdport_drive
    import adc_rdport_pkg::*;
#(
    parameter int RES_W  = 14,
    parameter int BUS_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic             rd_active,
    input  logic             addr_sel,
    input  logic             wide_mode,
    input  logic [RES_W-1:0] held,
    input  logic             eoc_n,
    input  half_ptr_e        ptr,
    input  logic             trk_active,
    input  logic             conv_active,
    input  logic             cal_active,
    input  logic             acq_settled,
    output logic [BUS_W-1:0] data_out,
    output logic [BUS_W-1:0] data_en
);
    localparam int LO_BITS  = RES_W - BYTE_W;
    localparam int LO_PAD   = BYTE_W - LO_BITS;
    localparam int WIDE_PAD = BUS_W - RES_W;
    localparam logic [BUS_W-1:0] EN_BYTE = {{(BUS_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

    logic [BYTE_W-1:0] status_byte;
    logic [BYTE_W-1:0] hi_half;
    logic [BYTE_W-1:0] lo_half;
    logic [BUS_W-1:0]  wide_word;

    // Top half of the sample, MSB first.
    assign hi_half = held[RES_W-1 -: BYTE_W];

    // Low half of the sample, left-aligned with trailing zeros when needed.
    if (LO_PAD > 0) begin : g_lo_pad
        assign lo_half = {held[LO_BITS-1:0], {LO_PAD{1'b0}}};
    end else begin : g_lo_full
        assign lo_half = held[LO_BITS-1:0];
    end

    // Wide word, left-aligned on the bus with zeros below.
    if (WIDE_PAD > 0) begin : g_wide_pad
        assign wide_word = {held, {WIDE_PAD{1'b0}}};
    end else begin : g_wide_full
        assign wide_word = held;
    end

    // Assemble the status byte from the flags and the phase inputs.
    always_comb begin
        status_byte          = '0;
        status_byte[ST_EOC]  = eoc_n;
        status_byte[ST_EOT]  = ~acq_settled;
        status_byte[ST_CONV] = conv_active;
        status_byte[ST_CAL]  = cal_active;
        status_byte[ST_RSV3] = 1'b0;
        status_byte[ST_PTR]  = (ptr == PTR_LOW);
        status_byte[ST_RSV1] = 1'b0;
        status_byte[ST_TRK]  = trk_active;
    end

    // Select the pin values and enables for the current read.
    always_comb begin
        data_out = '0;
        data_en  = '0;
        if (rd_active) begin
            if (!addr_sel) begin
                data_out[BYTE_W-1:0] = status_byte;
                data_en              = EN_BYTE;
            end else if (wide_mode) begin
                data_out = wide_word;
                data_en  = '1;
            end else begin
                data_out[BYTE_W-1:0] = (ptr == PTR_HIGH) ? hi_half : lo_half;
                data_en              = EN_BYTE;
            end
        end
    end
endmodule

// File: rtl/adc_rdport.sv
// Module: ADC result read port (top).
// Joins the strobe tracker, the holding buffer, the flag/pointer logic
// and the pin driver. Pins are modelled as value plus per-bit enable.
// Assumes all inputs are synchronous to clk.
module adc_rdport
    import adc_rdport_pkg::*;
#(
    parameter int RES_W  = 14,
    parameter int BUS_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    input  logic             trk_active,
    input  logic             conv_active,
    input  logic             cal_active,
    input  logic             acq_settled,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             addr_sel,
    input  logic             wide_mode,
    output logic [BUS_W-1:0] data_out,
    output logic [BUS_W-1:0] data_en
);
    logic             rd_active;
    logic             rd_end;
    logic             end_is_data;
    logic             end_is_wide;
    logic [RES_W-1:0] held;
    logic             load;
    logic             eoc_n;
    half_ptr_e        ptr;

    adc_rdport_strobe u_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .rd_n        (rd_n),
        .addr_sel    (addr_sel),
        .wide_mode   (wide_mode),
        .rd_active   (rd_active),
        .rd_end      (rd_end),
        .end_is_data (end_is_data),
        .end_is_wide (end_is_wide)
    );

    adc_rdport_buffer #(.RES_W(RES_W)) u_buffer (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .rd_active   (rd_active),
        .held_q      (held),
        .load        (load)
    );

    adc_rdport_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .rd_end      (rd_end),
        .end_is_data (end_is_data),
        .end_is_wide (end_is_wide),
        .eoc_n       (eoc_n),
        .ptr         (ptr)
    );

    adc_rdport_drive #(.RES_W(RES_W), .BUS_W(BUS_W), .BYTE_W(BYTE_W)) u_drive (
        .rd_active   (rd_active),
        .addr_sel    (addr_sel),
        .wide_mode   (wide_mode),
        .held        (held),
        .eoc_n       (eoc_n),
        .ptr         (ptr),
        .trk_active  (trk_active),
        .conv_active (conv_active),
        .cal_active  (cal_active),
        .acq_settled (acq_settled),
        .data_out    (data_out),
        .data_en     (data_en)
    );

    AST_HIZ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (data_en == '0)); // R2
    AST_STATUS_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n && !addr_sel) |-> (data_en[BUS_W-1:BYTE_W] == '0
            && data_out[ST_RSV3] == 1'b0 && data_out[ST_RSV1] == 1'b0)); // R3
endmodule

// File: tb/adc_rdport_bench.sv
module adc_rdport_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 1'b0;
    logic [13:0] conv_result = '0;
    logic        trk_active = 1'b0, conv_active = 1'b0, cal_active = 1'b0, acq_settled = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, addr_sel = 1'b0, wide_mode = 1'b0;
    logic [15:0] data_out, data_en;

    int total = 0;
    int bad = 0;
    logic        exp_eoc;
    logic        exp_ptr;
    logic [13:0] cur;
    logic [15:0] got_d, got_e;

    always #2 clk = ~clk;

    adc_rdport u_adc_rdport (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_result(conv_result),
        .trk_active(trk_active), .conv_active(conv_active), .cal_active(cal_active),
        .acq_settled(acq_settled), .cs_n(cs_n), .rd_n(rd_n), .addr_sel(addr_sel),
        .wide_mode(wide_mode), .data_out(data_out), .data_en(data_en)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] stat_exp();
        return {8'h00, exp_eoc, ~acq_settled, conv_active, cal_active, 1'b0, exp_ptr, 1'b0, trk_active};
    endfunction

    task automatic rd_begin(input logic a, input logic w);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr_sel = a; wide_mode = w;
        @(posedge clk); #1;
        got_d = data_out; got_e = data_en;
    endtask

    task automatic rd_finish();
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic do_read(input logic a, input logic w);
        rd_begin(a, w);
        rd_finish();
    endtask

    task automatic pulse(input logic [13:0] v);
        @(negedge clk);
        conv_done = 1'b1; conv_result = v;
        @(posedge clk); #1;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    // Status read with checks, followed by the flag update expected at read end.
    task automatic stat_read(input string tag);
        rd_begin(1'b0, 1'b0);
        chk({tag, " status"}, got_d, stat_exp());
        chk({tag, " status en"}, got_e, 16'h00FF);
        rd_finish();
        exp_eoc = 1'b1;
    endtask

    task automatic narrow_read(input string tag);
        rd_begin(1'b1, 1'b0);
        chk({tag, " narrow"}, got_d,
            exp_ptr ? {8'h00, cur[5:0], 2'b00} : {8'h00, cur[13:6]});
        chk({tag, " narrow en"}, got_e, 16'h00FF);
        rd_finish();
        exp_ptr = ~exp_ptr;
        exp_eoc = 1'b1;
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog expired got=running exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        exp_eoc = 1'b1; exp_ptr = 1'b0; cur = '0;
        repeat (5) @(posedge clk);
        #1;
        chk("R1 enable during reset", data_en, 16'h0000);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 enable after reset", data_en, 16'h0000);
        stat_read("R1 R3 reset");
        rd_begin(1'b1, 1'b1);
        chk("R1 R4 reset held zero", got_d, 16'h0000);
        rd_finish();

        // R2: one strobe alone never drives pins.
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b1; addr_sel = 1'b1;
        @(posedge clk); #1;
        chk("R2 cs only", data_en, 16'h0000);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
        @(posedge clk); #1;
        chk("R2 rd only", data_en, 16'h0000);
        @(negedge clk); rd_n = 1'b1;
        @(posedge clk); #1;

        // R3: sweep every phase input combination.
        for (int p = 0; p < 16; p++) begin
            @(negedge clk);
            {trk_active, conv_active, cal_active, acq_settled} = p[3:0];
            stat_read("R3 phase");
        end
        {trk_active, conv_active, cal_active, acq_settled} = 4'b0000;

        // R4..R9: many sample values with wide and narrow reads.
        for (int i = 0; i < 48; i++) begin
            logic [13:0] v;
            v = (i == 0) ? 14'h3FFF : (i == 1) ? 14'h0000 : 14'((i * 2731 + 5) & 16'h3FFF);
            if (i % 2 == 1) narrow_read("R6 pre");   // leave pointer on low half
            pulse(v);
            cur = v; exp_eoc = 1'b0; exp_ptr = 1'b0;
            stat_read("R8 R9 after load");           // S7=0, S2=0 expected
            stat_read("R8 cleared");                 // S7 back to 1
            for (int k = 0; k < 4; k++) narrow_read("R5 R6");
            narrow_read("R5 R6 odd");
            stat_read("R7 pointer low");
            rd_begin(1'b1, 1'b1);
            chk("R4 wide", got_d, {cur, 2'b00});
            chk("R4 wide en", got_e, 16'hFFFF);
            rd_finish();
            stat_read("R7 after wide");
            narrow_read("R7 continues");
        end

        // R10 R11: samples completing during a held read are deferred.
        cur = 14'h1234;
        pulse(cur);
        exp_eoc = 1'b0; exp_ptr = 1'b0;
        stat_read("R10 setup");
        rd_begin(1'b1, 1'b1);
        chk("R10 before", got_d, {cur, 2'b00});
        pulse(14'h2AAA);
        pulse(14'h0F0F);
        #1;
        chk("R10 held during read", data_out, {cur, 2'b00});
        rd_finish();
        cur = 14'h0F0F; exp_eoc = 1'b0; exp_ptr = 1'b0;
        stat_read("R10 R8 loaded at end");
        rd_begin(1'b1, 1'b1);
        chk("R11 newest loaded", got_d, {cur, 2'b00});
        rd_finish();
        narrow_read("R9 R5 after deferred");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule